// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Window

This block is the programmable front of a two-channel bus-master disk DMA engine. Each channel has an 8-byte I/O window. The window holds a command byte, a status byte and a 32-bit descriptor-table base pointer. Software may write or read the pointer one to four bytes at a time. Channel windows sit back to back from the base address `BASE`. The default base is 0xC000, which places channel 0 at 0xC000–0xC007 and channel 1 at 0xC008–0xC00F.

A start command arms a channel. The channel then asks a shared memory-request port for the 8-byte descriptor at `pointer + 8 × index`. When the data mover reports that a descriptor has been handled, the channel does one of two things. If the descriptor was not the last one, it advances the index and fetches again. If it was the last one, it clears its active flag and latches an interrupt flag. A stop command returns the channel to idle and rewinds the index. The data copy itself is outside this block.

Each channel runs a three-state machine:
- `CH_IDLE`: no request.
- `CH_FETCH`: descriptor request held on the fetch port until granted.
- `CH_WAIT`: waiting for a completion.

The transitions are:
- GO: `CH_IDLE`→`CH_FETCH`, on a start command.
- GRANTED: `CH_FETCH`→`CH_WAIT`, on a fetch grant.
- NEXT: `CH_WAIT`→`CH_FETCH`, on a completion that is not the last.
- FINISH: `CH_WAIT`→`CH_IDLE`, on the last completion.
- STOP: any state→`CH_IDLE`, on a command write with the start bit clear.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, every command, status and pointer byte reads 0, the table index is 0, all channels are in `CH_IDLE` and `fetch_valid` is low.
- R2: An address `BASE + 8*c + o` with c < NCH reaches channel c, and o selects the register: 0 is command, 2 is status, and 4..7 are pointer bytes 0..3 (byte 0 is least significant). An address outside the windows is ignored: no state change, `io_err` low and `io_rdata` 0.
- R3: An access to offset 1 or 3 raises `io_err` in the same cycle, returns 0 on `io_rdata` and changes no state.
- R4: `io_len` encodes the access size N as N−1. A pointer access of N bytes at offset 4+k is rejected when k+N > 4, with `io_err` high, read data 0 and no state change. Otherwise pointer bytes k..k+N−1 map to data lanes 0..N−1 (lane i is `io_wdata/io_rdata[8i+7:8i]`), and unused read lanes are 0. Read data is 0 for any write or rejected access.
- R5: A status access with N ≠ 1 is rejected with `io_err` high and no state change. A valid 1-byte status write replaces the whole status byte.
- R6: A command write with bit 0 (start) clear does three things: it sets the table index to 0, returns the channel to `CH_IDLE` (dropping any request), and clears status bit 0 (active).
- R7: A command write with bit 0 set in `CH_IDLE` sets status bit 0 and raises a fetch request. The request carries address `pointer + 8*index` and direction `fetch_rd` equal to command bit 3.
- R8: A completion in `CH_WAIT` with `done_last` low increments the index and issues the next descriptor fetch. With `done_last` high, it clears status bit 0, sets status bit 2 (interrupt) and returns to `CH_IDLE`.
- R9: `irq_set[c]` sets status bit 2 of channel c. When a status write, a completion or an interrupt raise fall in the same cycle, the write is applied first, and the completion and interrupt then override bits 0 and 2.
- R10: Channels share one fetch port, and the lowest-numbered requesting channel wins. `fetch_chan` names the winner, and a grant (`fetch_valid && fetch_ready`) moves only that channel to `CH_WAIT`.
- R11: A completion aimed at a channel that is not in `CH_WAIT` leaves its status, index and state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O access strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | I/O address |
| io_len | input | 2 | Access size minus one (1–4 bytes) |
| io_wdata | input | 32 | Write data, lane 0 first |
| io_rdata | output | 32 | Read data, same cycle |
| io_err | output | 1 | Rejected access in the window, same cycle |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | 32 | Descriptor address |
| fetch_chan | output | CH_W | Requesting channel |
| fetch_rd | output | 1 | Transfer direction from command bit 3 |
| done_valid | input | 1 | Descriptor completion |
| done_chan | input | CH_W | Channel of the completion |
| done_last | input | 1 | Completed descriptor was the last one |
| irq_set | input | NCH | Per-channel interrupt raise |

## Verification
The collision of interest is a software status write landing in the same cycle as the final completion of the same channel. The bench holds a status write of 0x02 on the I/O port while it pulses `done_valid` with `done_last`. It then reads the status back and expects 0x06: the written error bit is kept, active is cleared by the completion, and interrupt is set by it. A second overlap comes from two channels requesting fetches at once. The bench judges it by checking which channel `fetch_chan` names before and after the first grant.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    typedef enum logic [1:0] {CH_IDLE, CH_FETCH, CH_WAIT} ch_state_e;
    typedef enum logic [1:0] {SEL_NONE, SEL_CMD, SEL_STAT, SEL_PTR} reg_sel_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int ST_ACTIVE_BIT = 0;
    localparam int ST_INT_BIT    = 2;
    localparam int WIN_BYTES     = 8;
    localparam int PTR_BYTES     = 4;
    localparam int DESC_SHIFT    = 3;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hC000,
    parameter int NCH = 2,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        len_m1,
    output logic              hit,
    output logic [CH_W-1:0]   chan,
    output reg_sel_e          sel,
    output logic [1:0]        lane,
    output logic              bad
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel  = addr - BASE;
        hit  = valid && (addr >= BASE) && (rel < ADDR_W'(WIN_BYTES * NCH));
        chan = rel[3 +: CH_W];
        lane = rel[1:0];
        sel  = SEL_NONE;
        bad  = 1'b1;
        unique case (rel[2:0])
            3'd0: begin
                sel = SEL_CMD;
                bad = 1'b0;
            end
            3'd2: begin
                sel = SEL_STAT;
                bad = (len_m1 != 2'd0);
            end
            3'd4, 3'd5, 3'd6, 3'd7: begin
                sel = SEL_PTR;
                bad = ({1'b0, rel[1:0]} + {1'b0, len_m1}) > 3'd3;
            end
            default: begin
                sel = SEL_NONE;
                bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_wdata,
    input  logic             stat_we,
    input  logic [7:0]       stat_wdata,
    input  logic [3:0]       ptr_be,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             grant,
    input  logic             done,
    input  logic             done_last,
    input  logic             irq_set,
    output logic [7:0]       cmd_q,
    output logic [7:0]       stat_q,
    output logic [PTR_W-1:0] ptr_q,
    output logic             req,
    output logic [PTR_W-1:0] req_addr,
    output logic             req_rd
);
    ch_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             go, stop, step, fin;
    logic [7:0]       stat_d;

    always_comb begin
        go   = cmd_we && cmd_wdata[CMD_START_BIT] && (state_q == CH_IDLE);
        stop = cmd_we && !cmd_wdata[CMD_START_BIT];
        step = (state_q == CH_WAIT) && done && !done_last && !stop;
        fin  = (state_q == CH_WAIT) && done && done_last;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = CH_IDLE;                       // STOP
        end else begin
            unique case (state_q)
                CH_IDLE:  if (go)    state_d = CH_FETCH;  // GO
                CH_FETCH: if (grant) state_d = CH_WAIT;   // GRANTED
                CH_WAIT: begin
                    if (fin)       state_d = CH_IDLE;     // FINISH
                    else if (step) state_d = CH_FETCH;    // NEXT
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        stat_d = stat_we ? stat_wdata : stat_q;
        if (go)             stat_d[ST_ACTIVE_BIT] = 1'b1;
        if (fin || stop)    stat_d[ST_ACTIVE_BIT] = 1'b0;
        if (fin || irq_set) stat_d[ST_INT_BIT]    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            stat_q <= '0;
            ptr_q  <= '0;
            idx_q  <= '0;
        end else begin
            if (cmd_we) cmd_q <= cmd_wdata;
            stat_q <= stat_d;
            for (int b = 0; b < PTR_BYTES; b++) begin
                if (ptr_be[b]) ptr_q[8*b +: 8] <= ptr_wdata[8*b +: 8];
            end
            if (stop)      idx_q <= '0;
            else if (step) idx_q <= idx_q + 1'b1;
        end
    end

    // output process
    always_comb begin
        req      = (state_q == CH_FETCH);
        req_addr = ptr_q + PTR_W'({idx_q, {DESC_SHIFT{1'b0}}});
        req_rd   = cmd_q[CMD_DIR_BIT];
    end

    assert_go_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CMD_START_BIT] && state_q == CH_IDLE) |=> (stat_q[ST_ACTIVE_BIT] && req));

    assert_stop_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_wdata[CMD_START_BIT]) |=> (idx_q == '0 && !req && !stat_q[ST_ACTIVE_BIT]));

    assert_finish_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT && done && done_last && !cmd_we) |=>
            (!stat_q[ST_ACTIVE_BIT] && stat_q[ST_INT_BIT] && state_q == CH_IDLE));

    assert_idle_done_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && done && !stat_we && !irq_set && !cmd_we) |=>
            ($stable(stat_q) && $stable(idx_q) && state_q == CH_IDLE));
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hC000,
    parameter int NCH = 2,
    parameter int IDX_W = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PTR_W = 8 * PTR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_len,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              io_err,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [31:0]       fetch_addr,
    output logic [CH_W-1:0]   fetch_chan,
    output logic              fetch_rd,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_chan,
    input  logic              done_last,
    input  logic [NCH-1:0]    irq_set
);
    logic            hit, bad, acc_ok;
    logic [CH_W-1:0] chan;
    reg_sel_e        sel;
    logic [1:0]      lane;
    logic [3:0]      len_mask, ptr_be;
    logic [31:0]     lane_bits, ptr_wdata;

    bmdma_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .NCH(NCH)) u_decode (
        .valid(io_valid), .addr(io_addr), .len_m1(io_len),
        .hit(hit), .chan(chan), .sel(sel), .lane(lane), .bad(bad)
    );

    always_comb begin
        unique case (io_len)
            2'd0:    len_mask = 4'b0001;
            2'd1:    len_mask = 4'b0011;
            2'd2:    len_mask = 4'b0111;
            default: len_mask = 4'b1111;
        endcase
        for (int b = 0; b < PTR_BYTES; b++) lane_bits[8*b +: 8] = {8{len_mask[b]}};
        acc_ok    = hit && !bad;
        io_err    = hit && bad;
        ptr_be    = (acc_ok && io_write && sel == SEL_PTR) ? 4'(len_mask << lane) : 4'b0000;
        ptr_wdata = io_wdata << {lane, 3'b000};
    end

    logic [7:0]       cmd_a  [NCH];
    logic [7:0]       stat_a [NCH];
    logic [PTR_W-1:0] ptr_a  [NCH];
    logic [PTR_W-1:0] raddr_a[NCH];
    logic [NCH-1:0]   req, rd_v, grant;
    logic [CH_W-1:0]  win;
    logic             any;

    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = CH_W'(i);
                any = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_me;
        assign sel_me   = acc_ok && io_write && (chan == CH_W'(g));
        assign grant[g] = fetch_ready && any && (win == CH_W'(g));

        bmdma_chan #(.PTR_W(PTR_W), .IDX_W(IDX_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .cmd_we(sel_me && sel == SEL_CMD), .cmd_wdata(io_wdata[7:0]),
            .stat_we(sel_me && sel == SEL_STAT), .stat_wdata(io_wdata[7:0]),
            .ptr_be((chan == CH_W'(g)) ? ptr_be : 4'b0000), .ptr_wdata(ptr_wdata),
            .grant(grant[g]),
            .done(done_valid && done_chan == CH_W'(g)), .done_last(done_last),
            .irq_set(irq_set[g]),
            .cmd_q(cmd_a[g]), .stat_q(stat_a[g]), .ptr_q(ptr_a[g]),
            .req(req[g]), .req_addr(raddr_a[g]), .req_rd(rd_v[g])
        );
    end

    always_comb begin
        fetch_valid = any;
        fetch_chan  = win;
        fetch_addr  = raddr_a[win];
        fetch_rd    = rd_v[win];
    end

    always_comb begin
        io_rdata = '0;
        if (acc_ok && !io_write) begin
            unique case (sel)
                SEL_CMD:  io_rdata = {24'b0, cmd_a[chan]};
                SEL_STAT: io_rdata = {24'b0, stat_a[chan]};
                SEL_PTR:  io_rdata = (ptr_a[chan] >> {lane, 3'b000}) & lane_bits;
                default:  io_rdata = '0;
            endcase
        end
    end

    always_comb begin
        if (io_err) begin
            assert_err_zero_R3: assert (io_rdata == '0);
        end
    end

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_low_chan_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (fetch_valid && fetch_chan == '0));
endmodule

// File: tb/bmdma_regfile_tb.sv
`timescale 1ns/1ps
module bmdma_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_len = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_err;
    logic        fetch_valid, fetch_ready = 1'b0, fetch_rd;
    logic [31:0] fetch_addr;
    logic [0:0]  fetch_chan;
    logic        done_valid = 1'b0, done_last = 1'b0;
    logic [0:0]  done_chan = '0;
    logic [1:0]  irq_set = '0;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bmdma_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_len(io_len), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_err(io_err), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_chan(fetch_chan), .fetch_rd(fetch_rd),
        .done_valid(done_valid), .done_chan(done_chan), .done_last(done_last),
        .irq_set(irq_set)
    );

    typedef struct packed {
        logic        w;
        logic [15:0] a;
        logic [2:0]  n;
        logic [31:0] d;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'hC000, 3'd1, 32'h0,        32'h0,        1'b0, 4'd1}, // R1 cmd after reset
        '{1'b0, 16'hC002, 3'd1, 32'h0,        32'h0,        1'b0, 4'd1}, // R1 status after reset
        '{1'b1, 16'hC004, 3'd4, 32'h12345678, 32'h0,        1'b0, 4'd4}, // R4 full pointer write
        '{1'b0, 16'hC004, 3'd4, 32'h0,        32'h12345678, 1'b0, 4'd4}, // R4
        '{1'b0, 16'hC006, 3'd2, 32'h0,        32'h00001234, 1'b0, 4'd4}, // R4 upper half
        '{1'b0, 16'hC007, 3'd1, 32'h0,        32'h00000012, 1'b0, 4'd4}, // R4 top byte
        '{1'b0, 16'hC005, 3'd4, 32'h0,        32'h0,        1'b1, 4'd4}, // R4 overrun read
        '{1'b1, 16'hC006, 3'd4, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd4}, // R4 overrun write
        '{1'b0, 16'hC004, 3'd4, 32'h0,        32'h12345678, 1'b0, 4'd4}, // R4 unchanged
        '{1'b0, 16'hC001, 3'd1, 32'h0,        32'h0,        1'b1, 4'd3}, // R3 offset 1
        '{1'b1, 16'hC003, 3'd1, 32'hFF,       32'h0,        1'b1, 4'd3}, // R3 offset 3
        '{1'b1, 16'hC002, 3'd2, 32'h0707,     32'h0,        1'b1, 4'd5}, // R5 wide status write
        '{1'b0, 16'hC002, 3'd1, 32'h0,        32'h0,        1'b0, 4'd5}, // R5 status unchanged
        '{1'b1, 16'hC00C, 3'd4, 32'hAABBCCDD, 32'h0,        1'b0, 4'd2}, // R2 channel 1 pointer
        '{1'b0, 16'hC00C, 3'd4, 32'h0,        32'hAABBCCDD, 1'b0, 4'd2}, // R2
        '{1'b0, 16'hC004, 3'd4, 32'h0,        32'h12345678, 1'b0, 4'd2}, // R2 channel 0 kept
        '{1'b0, 16'hC010, 3'd1, 32'h0,        32'h0,        1'b0, 4'd2}, // R2 outside window
        '{1'b1, 16'hC005, 3'd2, 32'h0000BEEF, 32'h0,        1'b0, 4'd4}, // R4 middle bytes
        '{1'b0, 16'hC004, 3'd4, 32'h0,        32'h12BEEF78, 1'b0, 4'd4}, // R4
        '{1'b1, 16'hC002, 3'd1, 32'h06,       32'h0,        1'b0, 4'd5}, // R5 status write
        '{1'b0, 16'hC002, 3'd1, 32'h0,        32'h06,       1'b0, 4'd5}  // R5 readback
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_op(input bit w, input logic [15:0] a, input int n, input logic [31:0] d,
                         output logic [31:0] rd, output logic er);
        @(negedge clk);
        io_valid = 1'b1; io_write = w; io_addr = a; io_len = 2'(n - 1); io_wdata = d;
        #1;
        rd = io_rdata;
        er = io_err;
        @(posedge clk);
        #1 io_valid = 1'b0; io_write = 1'b0;
    endtask

    task automatic grant_one();
        @(negedge clk); fetch_ready = 1'b1;
        @(posedge clk); #1 fetch_ready = 1'b0;
    endtask

    task automatic done_pulse(input logic ch, input logic last);
        @(negedge clk); done_valid = 1'b1; done_chan = ch; done_last = last;
        @(posedge clk); #1 done_valid = 1'b0; done_last = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic er;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 fetch_valid after reset", 32'(fetch_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            io_op(VEC[i].w, VEC[i].a, int'(VEC[i].n), VEC[i].d, rd, er);
            chk($sformatf("R%0d vector %0d rdata", VEC[i].rq, i), rd, VEC[i].exp_rd);
            chk($sformatf("R%0d vector %0d err", VEC[i].rq, i), 32'(er), 32'(VEC[i].exp_err));
        end
        io_op(1'b1, 16'hC002, 1, 32'h00, rd, er);

        // R7: start channel 0, read direction
        io_op(1'b1, 16'hC000, 1, 32'h09, rd, er);
        chk("R7 fetch_valid", 32'(fetch_valid), 32'h1);
        chk("R7 fetch_addr", fetch_addr, 32'h12BEEF78);
        chk("R7 fetch_rd", 32'(fetch_rd), 32'h1);
        chk("R7 fetch_chan", 32'(fetch_chan), 32'h0);
        io_op(1'b0, 16'hC002, 1, 32'h0, rd, er);
        chk("R7 active set", rd, 32'h01);
        io_op(1'b0, 16'hC000, 1, 32'h0, rd, er);
        chk("R2 cmd readback", rd, 32'h09);

        grant_one();
        chk("R10 request dropped after grant", 32'(fetch_valid), 32'h0);

        // R8: non-last completion advances
        done_pulse(1'b0, 1'b0);
        chk("R8 next fetch valid", 32'(fetch_valid), 32'h1);
        chk("R8 next fetch addr", fetch_addr, 32'h12BEEF80);
        grant_one();

        // R9: status write and last completion in one cycle
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b1; io_addr = 16'hC002; io_len = 2'd0; io_wdata = 32'h02;
        done_valid = 1'b1; done_chan = 1'b0; done_last = 1'b1;
        @(posedge clk);
        #1 io_valid = 1'b0; io_write = 1'b0; done_valid = 1'b0; done_last = 1'b0;
        io_op(1'b0, 16'hC002, 1, 32'h0, rd, er);
        chk("R9 write+finish merge", rd, 32'h06);
        chk("R8 idle after finish", 32'(fetch_valid), 32'h0);

        // R11: completion to idle channel
        io_op(1'b1, 16'hC002, 1, 32'h00, rd, er);
        done_pulse(1'b0, 1'b1);
        io_op(1'b0, 16'hC002, 1, 32'h0, rd, er);
        chk("R11 idle completion ignored", rd, 32'h00);
        chk("R11 no request", 32'(fetch_valid), 32'h0);

        // R7: index held, write direction
        io_op(1'b1, 16'hC000, 1, 32'h01, rd, er);
        chk("R7 held index addr", fetch_addr, 32'h12BEEF80);
        chk("R7 write direction", 32'(fetch_rd), 32'h0);

        // R6: stop rewinds
        io_op(1'b1, 16'hC000, 1, 32'h00, rd, er);
        chk("R6 request dropped", 32'(fetch_valid), 32'h0);
        io_op(1'b0, 16'hC002, 1, 32'h0, rd, er);
        chk("R6 active cleared", rd, 32'h00);
        io_op(1'b1, 16'hC000, 1, 32'h01, rd, er);
        chk("R6 index rewound", fetch_addr, 32'h12BEEF78);

        // R10: both channels requesting
        io_op(1'b1, 16'hC008, 1, 32'h01, rd, er);
        chk("R10 low channel first", 32'(fetch_chan), 32'h0);
        chk("R10 low channel addr", fetch_addr, 32'h12BEEF78);
        grant_one();
        chk("R10 second channel chan", 32'(fetch_chan), 32'h1);
        chk("R10 second channel addr", fetch_addr, 32'hAABBCCDD);
        grant_one();
        chk("R10 all granted", 32'(fetch_valid), 32'h0);

        // R9: interrupt raise
        @(negedge clk); irq_set = 2'b10;
        @(posedge clk); #1 irq_set = 2'b00;
        io_op(1'b0, 16'hC00A, 1, 32'h0, rd, er);
        chk("R9 irq sets bit 2", rd, 32'h05);
        io_op(1'b0, 16'hC002, 1, 32'h0, rd, er);
        chk("R9 other channel untouched", rd, 32'h01);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 no request after reset", 32'(fetch_valid), 32'h0);
        io_op(1'b0, 16'hC004, 4, 32'h0, rd, er);
        chk("R1 pointer cleared", rd, 32'h0);
        io_op(1'b0, 16'hC00A, 1, 32'h0, rd, er);
        chk("R1 status cleared", rd, 32'h0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule